// File: doc/BRIEF.md
# Overlay Blanking and Contrast-Level Output Stage

This block is the last stage of an on-screen text or graphics overlay generator. On every pixel-clock enable it registers the internally generated blanking flag, contrast-reduction flag and RGB pixel word, and drives them to the chip's overlay outputs. Blanking passes straight through. The RGB word and the contrast flag first go through a short delay line. A two-bit setting picks a delay of zero to three whole pixels, so that downstream parts that add delay to the blanking signal can be lined up with the pixel data.

A combined level output carries the contrast information to one analog pin. In the default mode the level code is the delayed contrast flag alone. In the alternative mode it is a three-level code that merges the undelayed blanking flag with the delayed contrast flag. When both flags are active, blanking wins.

Every output has one register of latency, counted in pixel enables. When the enable is low, all outputs hold their values.

Top module: `ovl_out_stage`

## Requirements
- R1: While reset is high, and after it falls up to the first pixel enable, blank_o is 0, rgb_o is 0 and lvl_o is 2'b00.
- R2: In a clock cycle where pix_en is low, none of blank_o, rgb_o or lvl_o changes.
- R3: After each enable, blank_o equals the blank_i sampled at that same enable, for any value of dly_sel.
- R4: After enable number n, rgb_o equals the rgb_i sampled at enable n−d, where d is the value of dly_sel (0 to 3). Only enables are counted, not clock cycles. If enable n−d falls before reset was released, rgb_o is 0.
- R5: The contrast flag uses the same delay as in R4. The delayed flag, called cor_d, is the cor_i sampled at enable n−d, or 0 if that enable falls before reset was released.
- R6: When three_lvl is 0 at an enable, lvl_o becomes {1'b0, cor_d}. blank_i has no effect on lvl_o in this mode.
- R7: When three_lvl is 1 at an enable, lvl_o becomes 2'b10 if blank_i is 1, whatever cor_d is. Otherwise it becomes 2'b01 if cor_d is 1, and 2'b00 if not.
- R8: lvl_o never takes the value 2'b11.
- R9: A new dly_sel or three_lvl value present at an enable takes effect in the outputs of that enable. No extra pixel of the old setting appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | Pixel-clock enable; one pulse per pixel |
| three_lvl | input | 1 | 0: two-level contrast code; 1: three-level code |
| dly_sel | input | DLY_W (2) | Delay of RGB and contrast, in pixels |
| blank_i | input | 1 | Blanking flag from the pixel generator |
| cor_i | input | 1 | Contrast-reduction flag from the pixel generator |
| rgb_i | input | RGB_W | Pixel colour word |
| blank_o | output | 1 | Registered blanking, never delayed |
| rgb_o | output | RGB_W | Registered, delayed pixel word |
| lvl_o | output | 2 | Level code: 00 clear, 01 contrast, 10 blank |

## Verification
The bench builds the block with RGB_W = 6 and the default MAX_DLY = 3. This keeps every delay tap within reach, and the pixel words stay small enough to be computed arithmetically from the pixel index. It sweeps all eight combinations of mode and delay over one continuous pixel stream. The stream cycles through all four blank/contrast pairs, so each setting change exercises the first pixel under the new tap. The sweep also covers the blank-over-contrast priority and the zero-history values just after reset. Idle cycles with changing inputs are inserted between pixels to show that the outputs hold.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

    typedef enum logic [1:0] {
        LVL_CLEAR    = 2'b00,
        LVL_CONTRAST = 2'b01,
        LVL_BLANK    = 2'b10
    } lvl_code_e;

    // Merge blanking and contrast into the output level code.
    function automatic lvl_code_e encode_level(
        input logic three_mode,
        input logic blank,
        input logic contrast
    );
        lvl_code_e code;
        if (three_mode && blank)
            code = LVL_BLANK;
        else if (contrast)
            code = LVL_CONTRAST;
        else
            code = LVL_CLEAR;
        return code;
    endfunction

endpackage

// File: rtl/ovl_pix_delay.sv
module ovl_pix_delay #(
    parameter int W     = 8,
    parameter int DEPTH = 3,
    localparam int SEL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic [W-1:0]     din,
    input  logic [SEL_W-1:0] sel,
    output logic [W-1:0]     dout
);

    logic [W-1:0] stage [DEPTH];

    generate
        for (genvar k = 0; k < DEPTH; k++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    stage[k] <= '0;
                else if (adv)
                    stage[k] <= (k == 0) ? din : stage[(k == 0) ? 0 : k-1];
            end
        end
    endgenerate

    // Tap 0 is the live input, tap k is k pixels old; larger selects clamp.
    always_comb begin
        dout = din;
        for (int k = 1; k <= DEPTH; k++) begin
            if (int'(sel) >= k)
                dout = stage[k-1];
        end
    end

endmodule

// File: rtl/ovl_level_enc.sv
module ovl_level_enc
    import ovl_pkg::*;
(
    input  logic      three_mode,
    input  logic      blank_now,
    input  logic      cor_late,
    output lvl_code_e code
);

    always_comb code = encode_level(three_mode, blank_now, cor_late);

endmodule

// File: rtl/ovl_out_stage.sv
module ovl_out_stage
    import ovl_pkg::*;
#(
    parameter int RGB_W   = 12,
    parameter int MAX_DLY = 3,
    localparam int DLY_W  = $clog2(MAX_DLY + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pix_en,
    input  logic             three_lvl,
    input  logic [DLY_W-1:0] dly_sel,
    input  logic             blank_i,
    input  logic             cor_i,
    input  logic [RGB_W-1:0] rgb_i,
    output logic             blank_o,
    output logic [RGB_W-1:0] rgb_o,
    output logic [1:0]       lvl_o
);

    typedef struct packed {
        logic [RGB_W-1:0] rgb;
        logic             cor;
    } pix_payload_t;

    localparam int PAY_W = $bits(pix_payload_t);

    pix_payload_t pay_in, pay_tap;
    lvl_code_e    code_nxt;

    assign pay_in = '{rgb: rgb_i, cor: cor_i};

    ovl_pix_delay #(.W(PAY_W), .DEPTH(MAX_DLY)) u_dly (
        .clk  (clk),
        .rst  (rst),
        .adv  (pix_en),
        .din  (pay_in),
        .sel  (dly_sel),
        .dout (pay_tap)
    );

    ovl_level_enc u_enc (
        .three_mode (three_lvl),
        .blank_now  (blank_i),
        .cor_late   (pay_tap.cor),
        .code       (code_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            blank_o <= 1'b0;
            rgb_o   <= '0;
            lvl_o   <= LVL_CLEAR;
        end else if (pix_en) begin
            blank_o <= blank_i;
            rgb_o   <= pay_tap.rgb;
            lvl_o   <= code_nxt;
        end
    end

endmodule

// File: rtl/ovl_out_chk.sv
module ovl_out_chk #(
    parameter int RGB_W   = 12,
    parameter int MAX_DLY = 3,
    localparam int DLY_W  = $clog2(MAX_DLY + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             pix_en,
    input logic             three_lvl,
    input logic [DLY_W-1:0] dly_sel,
    input logic             blank_i,
    input logic             cor_i,
    input logic [RGB_W-1:0] rgb_i,
    input logic             blank_o,
    input logic [RGB_W-1:0] rgb_o,
    input logic [1:0]       lvl_o
);

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (blank_o == 1'b0 && rgb_o == '0 && lvl_o == 2'b00));

    a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !pix_en |=> ($stable(blank_o) && $stable(rgb_o) && $stable(lvl_o)));

    a_r3_blank_direct: assert property (@(posedge clk) disable iff (rst)
        pix_en |=> (blank_o == $past(blank_i)));

    a_r4_zero_tap: assert property (@(posedge clk) disable iff (rst)
        (pix_en && dly_sel == '0) |=> (rgb_o == $past(rgb_i)));

    a_r6_two_level: assert property (@(posedge clk) disable iff (rst)
        (pix_en && !three_lvl) |=> !lvl_o[1]);

    a_r7_blank_code: assert property (@(posedge clk) disable iff (rst)
        (pix_en && three_lvl && blank_i) |=> (lvl_o == 2'b10));

    a_r8_no_code3: assert property (@(posedge clk) disable iff (rst)
        lvl_o != 2'b11);

endmodule

bind ovl_out_stage ovl_out_chk #(.RGB_W(RGB_W), .MAX_DLY(MAX_DLY)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pix_en    (pix_en),
    .three_lvl (three_lvl),
    .dly_sel   (dly_sel),
    .blank_i   (blank_i),
    .cor_i     (cor_i),
    .rgb_i     (rgb_i),
    .blank_o   (blank_o),
    .rgb_o     (rgb_o),
    .lvl_o     (lvl_o)
);

// File: tb/ovl_out_stage_test.sv
`timescale 1ns/1ps
module ovl_out_stage_test;

    localparam int RGB_W = 6;
    localparam int MAXD  = 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             pix_en = 1'b0;
    logic             three_lvl = 1'b0;
    logic [1:0]       dly_sel = 2'd0;
    logic             blank_i = 1'b0;
    logic             cor_i = 1'b0;
    logic [RGB_W-1:0] rgb_i = '0;
    logic             blank_o;
    logic [RGB_W-1:0] rgb_o;
    logic [1:0]       lvl_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [RGB_W-1:0] hist_rgb [512];
    logic             hist_cor [512];
    int               k = 0;

    always #2.5 clk = ~clk;

    ovl_out_stage #(.RGB_W(RGB_W), .MAX_DLY(MAXD)) uut (
        .clk(clk), .rst(rst), .pix_en(pix_en), .three_lvl(three_lvl),
        .dly_sel(dly_sel), .blank_i(blank_i), .cor_i(cor_i), .rgb_i(rgb_i),
        .blank_o(blank_o), .rgb_o(rgb_o), .lvl_o(lvl_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One pixel: drive at negedge, enable through one posedge, check at next negedge.
    task automatic pixel(input logic [RGB_W-1:0] rgb, input logic cor,
                         input logic blank, input string tag);
        int src;
        logic [RGB_W-1:0] e_rgb;
        logic e_cor;
        int e_lvl;
        rgb_i = rgb; cor_i = cor; blank_i = blank; pix_en = 1'b1;
        hist_rgb[k] = rgb; hist_cor[k] = cor;
        src = k - int'(dly_sel);
        e_rgb = (src >= 0) ? hist_rgb[src] : '0;
        e_cor = (src >= 0) ? hist_cor[src] : 1'b0;
        e_lvl = (three_lvl && blank) ? 2 : (e_cor ? 1 : 0);
        k++;
        @(negedge clk);
        pix_en = 1'b0;
        check({tag, " R3 blank"}, int'(blank_o), int'(blank));
        check({tag, " R4 rgb"}, int'(rgb_o), int'(e_rgb));
        check({tag, (three_lvl ? " R7 lvl" : " R6 R5 lvl")}, int'(lvl_o), e_lvl);
        check({tag, " R8 code"}, int'(lvl_o == 2'b11), 0);
    endtask

    task automatic idle(input int n);
        logic             b0;
        logic [RGB_W-1:0] r0;
        logic [1:0]       l0;
        b0 = blank_o; r0 = rgb_o; l0 = lvl_o;
        for (int i = 0; i < n; i++) begin
            rgb_i = ~rgb_i; cor_i = ~cor_i; blank_i = ~blank_i;
            @(negedge clk);
        end
        check("R2 hold", int'({b0, r0, l0}), int'({blank_o, rgb_o, lvl_o}));
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset lvl", int'({blank_o, rgb_o, lvl_o}), 0);
        rst = 1'b0;
        rgb_i = '1; cor_i = 1'b1; blank_i = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R1 before first enable", int'({blank_o, rgb_o, lvl_o}), 0);

        for (int m = 0; m < 2; m++) begin
            for (int d = 0; d <= MAXD; d++) begin
                three_lvl = m[0];
                dly_sel = d[1:0];
                for (int j = 0; j < 12; j++) begin
                    pixel(RGB_W'(k * 37 + j * 11 + 5), j[0], j[1],
                          (j == 0) ? "R9 first" : "sweep");
                    if (j % 5 == 4) idle(2);
                end
            end
        end

        // Delay drops from 3 to 0 and back up mid-stream.
        three_lvl = 1'b1;
        for (int j = 0; j < 8; j++) begin
            dly_sel = (j % 2 == 0) ? 2'd3 : 2'd0;
            pixel(RGB_W'(j * 13 + 2), j[1], j[2], "R9 switch");
        end

        // Blank and contrast together, delay 0, both modes.
        dly_sel = 2'd0;
        three_lvl = 1'b1;
        pixel(6'h2A, 1'b1, 1'b1, "R7 priority");
        three_lvl = 1'b0;
        pixel(6'h15, 1'b1, 1'b1, "R6 blank ignored");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule